// File: doc/BRIEF.md
# AXI4-Lite Register Master

This block turns one request on a simple user-side command port into one AXI4-Lite register access: a single write or a single read. The command carries the direction, the address, the write data, an optional byte-lane mask and two start delays. The delays let a system or a bench space the address and data channels of a write apart. On a write, the address and data channels are launched on their own schedules and handshaken independently. The write response is accepted only after both have completed. On a read, the address is launched after its delay and the first read beat that follows is captured.

When the access finishes, the master raises a one-cycle completion pulse. It then presents the read data, the two-bit response code and an error flag that is set for any response other than OKAY. These results hold until the next completion. The response channels are always ready, so the master never stalls a slave's reply. Only one access is in flight at a time.

Top module: `axil_reg_master`

## Requirements
- R1: After a cycle with `rst_n` low, `m_awvalid`, `m_wvalid`, `m_arvalid`, `busy` and `done` are all 0.
- R2: `m_bready` and `m_rready` are 1 in every cycle, including during reset.
- R3: A command is taken on a clock edge where `cmd_req` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the completion cycle. A `cmd_req` raised while `busy` is 1 starts no bus activity.
- R4: On a write, `m_awvalid` first reads high after the edge that follows the accepting edge by `cmd_addr_dly` cycles (0 means the cycle right after acceptance). On a read, `m_arvalid` follows the same rule with the same delay.
- R5: On a write, `m_wvalid` first reads high after the edge that follows the accepting edge by `cmd_data_dly` cycles, whatever the address delay is.
- R6: Each VALID (`m_awvalid`, `m_wvalid`, `m_arvalid`) stays high with a stable payload until the edge where its READY is high, and is low in the next cycle. The payload carries the command's address or data.
- R7: `m_wstrb` equals `cmd_strb` when `cmd_strb_use` is 1, and is all ones when `cmd_strb_use` is 0.
- R8: A write ends with a one-cycle `done` pulse in the cycle after the edge that accepts a write-response beat. That beat counts only once both the address and data handshakes are complete.
- R9: A read ends with a one-cycle `done` pulse in the cycle after the edge that accepts the read beat. `rd_data` then holds that beat's data.
- R10: At completion, `resp_code` holds the received BRESP or RRESP, and `err` is 1 exactly when that code is not 2'b00 (OKAY). Both hold until the next completion.
- R11: A reset during a transaction drops every VALID and `busy` and abandons the access: no `done` follows for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_req | input | 1 | Command request, taken when not busy |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_strb | input | DATA_W/8 | Byte-lane mask for a write |
| cmd_strb_use | input | 1 | 1 = use cmd_strb, 0 = all lanes |
| cmd_addr_dly | input | DLY_W | Cycles before address VALID |
| cmd_data_dly | input | DLY_W | Cycles before write-data VALID |
| busy | output | 1 | An access is in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Data of the last read |
| err | output | 1 | Last response was not OKAY |
| resp_code | output | 2 | Last response code |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready (always 1) |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read address |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready (always 1) |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |

## Verification
A lane launcher stuck in its wait state or its count off by one shows up at once as a VALID that rises early or late relative to the programmed delay. It also shows as a `done` that never arrives, which the bench catches within a few hundred cycles. A lane that forgets its finished state lets a write complete before both handshakes, or hangs it. This shows up as a missing or early `done`, or as two address handshakes for one command. A corrupted payload or response register appears at the handshake or at the completion cycle as the wrong address, data, strobe, code or error flag. A sequencer that does not return to idle leaves `busy` high and blocks the next command.

// File: rtl/axil_master_pkg.sv
// Package: shared state encodings and lane indices for the AXI4-Lite
// register master. Assumes a single outstanding access at a time.
package axil_master_pkg;

    // Top-level sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } mst_state_e;

    // Per-channel launcher states
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_WAIT  = 2'd1,
        LN_VALID = 2'd2,
        LN_DONE  = 2'd3
    } lane_state_e;

    // Request channel lanes driven by the master
    localparam int CH_AW  = 0;
    localparam int CH_W   = 1;
    localparam int CH_AR  = 2;
    localparam int NUM_CH = 3;

    // Response encoding treated as success
    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axil_chan_launch.sv
// Module: axil_chan_launch
// Launches one AXI request channel (address or data). On `start` it loads
// a delay, counts it down, then holds `valid` high until `ready` is seen
// on a clock edge. It stays in a finished state until the next start.
// Assumes `start` is only pulsed while the lane is not presenting VALID.
module axil_chan_launch
    import axil_master_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] dly,
    input  logic             ready,
    output logic             valid,
    output logic             finished
);

    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    lane_state_e      state_q;
    logic [DLY_W-1:0] cnt_q;

    // Lane sequencing: delay countdown, VALID hold, finished flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            cnt_q   <= dly;
            state_q <= (dly == '0) ? LN_VALID : LN_WAIT;
        end else begin
            case (state_q)
                LN_WAIT: begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) begin
                        state_q <= LN_VALID;
                    end
                end
                LN_VALID: begin
                    if (ready) begin
                        state_q <= LN_DONE;
                    end
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

    // Outputs decoded straight from the state register
    assign valid    = (state_q == LN_VALID);
    assign finished = (state_q == LN_DONE);

endmodule

// File: rtl/axil_resp_sink.sv
// Module: axil_resp_sink
// Accepts the write or read response beat once the sequencer says it is
// waiting for one. It registers completion, the response code, the error
// flag and the read data. The results hold until the next beat.
// Assumes only one of wait_wr / wait_rd is high at a time.
module axil_resp_sink
    import axil_master_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wait_wr,
    input  logic              wait_rd,
    input  logic              bvalid,
    input  logic [1:0]        bresp,
    input  logic              rvalid,
    input  logic [1:0]        rresp,
    input  logic [DATA_W-1:0] rdata,
    output logic              beat,
    output logic              done,
    output logic              err,
    output logic [1:0]        code,
    output logic [DATA_W-1:0] rd_data
);

    logic wr_beat;
    logic rd_beat;

    // Qualify response beats by what the sequencer is waiting for
    always_comb begin
        wr_beat = wait_wr && bvalid;
        rd_beat = wait_rd && rvalid;
        beat    = wr_beat || rd_beat;
    end

    // Completion pulse and held response results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            err     <= 1'b0;
            code    <= RESP_OKAY;
            rd_data <= '0;
        end else begin
            done <= beat;
            if (wr_beat) begin
                code <= bresp;
                err  <= (bresp != RESP_OKAY);
            end else if (rd_beat) begin
                code    <= rresp;
                err     <= (rresp != RESP_OKAY);
                rd_data <= rdata;
            end
        end
    end

endmodule

// File: rtl/axil_reg_master.sv
// Module: axil_reg_master
// Single-beat AXI4-Lite master. It takes one user command when idle,
// launches the request channels through per-lane launchers (the address
// and data of a write are independent), and finishes on the response
// beat. Response readies are tied high.
// Assumes: one access in flight, and no bursts, IDs or attributes.
module axil_reg_master
    import axil_master_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DLY_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_req,
    input  logic                  cmd_write,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic [DATA_W/8-1:0]   cmd_strb,
    input  logic                  cmd_strb_use,
    input  logic [DLY_W-1:0]      cmd_addr_dly,
    input  logic [DLY_W-1:0]      cmd_data_dly,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  err,
    output logic [1:0]            resp_code,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_wstrb,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    input  logic [1:0]            m_bresp,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    output logic [ADDR_W-1:0]     m_araddr,
    input  logic                  m_rvalid,
    output logic                  m_rready,
    input  logic [DATA_W-1:0]     m_rdata,
    input  logic [1:0]            m_rresp
);

    localparam int STRB_W = DATA_W / 8;

    mst_state_e          state_q;
    logic                accept;
    logic                resp_beat;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [STRB_W-1:0]   strb_q;

    logic [NUM_CH-1:0]   lane_start;
    logic [NUM_CH-1:0]   lane_ready;
    logic [NUM_CH-1:0]   lane_valid;
    logic [NUM_CH-1:0]   lane_fin;
    logic [DLY_W-1:0]    lane_dly [NUM_CH];

    // Command acceptance only from idle
    assign accept = cmd_req && (state_q == ST_IDLE);

    // Lane start, delay and ready routing
    always_comb begin
        lane_start[CH_AW] = accept && cmd_write;
        lane_start[CH_W]  = accept && cmd_write;
        lane_start[CH_AR] = accept && !cmd_write;
        lane_dly[CH_AW]   = cmd_addr_dly;
        lane_dly[CH_W]    = cmd_data_dly;
        lane_dly[CH_AR]   = cmd_addr_dly;
        lane_ready[CH_AW] = m_awready;
        lane_ready[CH_W]  = m_wready;
        lane_ready[CH_AR] = m_arready;
    end

    // One launcher per request channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        axil_chan_launch #(
            .DLY_W (DLY_W)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (lane_start[g]),
            .dly      (lane_dly[g]),
            .ready    (lane_ready[g]),
            .valid    (lane_valid[g]),
            .finished (lane_fin[g])
        );
    end

    // Sequencer: idle -> write/read -> idle on the response beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept) state_q <= cmd_write ? ST_WRITE : ST_READ;
                ST_WRITE: if (resp_beat) state_q <= ST_IDLE;
                ST_READ:  if (resp_beat) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Command payload capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else if (accept) begin
            addr_q <= cmd_addr;
            data_q <= cmd_wdata;
            strb_q <= cmd_strb_use ? cmd_strb : {STRB_W{1'b1}};
        end
    end

    // Response collection and result registers
    axil_resp_sink #(
        .DATA_W (DATA_W)
    ) i_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_wr (state_q == ST_WRITE && lane_fin[CH_AW] && lane_fin[CH_W]),
        .wait_rd (state_q == ST_READ && lane_fin[CH_AR]),
        .bvalid  (m_bvalid),
        .bresp   (m_bresp),
        .rvalid  (m_rvalid),
        .rresp   (m_rresp),
        .rdata   (m_rdata),
        .beat    (resp_beat),
        .done    (done),
        .err     (err),
        .code    (resp_code),
        .rd_data (rd_data)
    );

    // Bus outputs
    assign busy      = (state_q != ST_IDLE);
    assign m_awvalid = lane_valid[CH_AW];
    assign m_wvalid  = lane_valid[CH_W];
    assign m_arvalid = lane_valid[CH_AR];
    assign m_awaddr  = addr_q;
    assign m_araddr  = addr_q;
    assign m_wdata   = data_q;
    assign m_wstrb   = strb_q;
    assign m_bready  = 1'b1;
    assign m_rready  = 1'b1;

endmodule

// File: rtl/axil_reg_master_chk.sv
// Module: axil_reg_master_chk
// Protocol and user-port checks for axil_reg_master, bound into every
// instance. Assumes a synchronous active-low reset.
module axil_reg_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic                err,
    input logic                m_awvalid,
    input logic                m_awready,
    input logic [ADDR_W-1:0]   m_awaddr,
    input logic                m_wvalid,
    input logic                m_wready,
    input logic [DATA_W-1:0]   m_wdata,
    input logic [DATA_W/8-1:0] m_wstrb,
    input logic                m_arvalid,
    input logic                m_arready,
    input logic [ADDR_W-1:0]   m_araddr,
    input logic                m_bready,
    input logic                m_rready
);

    // R2
    resp_ready_chk: assert property (@(posedge clk) m_bready && m_rready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_awvalid && !m_wvalid && !m_arvalid);

    // R6
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

    // R6
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb));

    // R6
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

    // R6
    aw_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && m_awready |=> !m_awvalid);

    // R6
    w_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid && m_wready |=> !m_wvalid);

    // R6
    ar_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && m_arready |=> !m_arvalid);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R3
    done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind axil_reg_master axil_reg_master_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (.*);

// File: tb/test_axil_reg_master.sv
`timescale 1ns/1ps
module test_axil_reg_master;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DL = 4;

    typedef struct packed {
        logic          wr;
        logic [31:0]   addr;
        logic [31:0]   data;
        logic [3:0]    strb;
        logic          strb_use;
        logic [3:0]    adly;
        logic [3:0]    ddly;
        logic [3:0]    lat;
        logic [1:0]    resp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0010, 32'hDEAD_BEEF, 4'h3, 1'b1, 4'd0, 4'd0, 4'd0, 2'b00},
        '{1'b1, 32'h0000_0024, 32'h1234_5678, 4'h0, 1'b0, 4'd3, 4'd0, 4'd1, 2'b00},
        '{1'b1, 32'h0000_0100, 32'hCAFE_F00D, 4'h8, 1'b1, 4'd0, 4'd5, 4'd2, 2'b10},
        '{1'b0, 32'h0000_0040, 32'h0000_0000, 4'h0, 1'b0, 4'd2, 4'd0, 4'd3, 2'b00},
        '{1'b0, 32'h0000_0ABC, 32'h0000_0000, 4'h0, 1'b0, 4'd0, 4'd9, 4'd0, 2'b11},
        '{1'b1, 32'hFFFF_FFFC, 32'h0F0F_0F0F, 4'hC, 1'b1, 4'd7, 4'd7, 4'd0, 2'b01},
        '{1'b1, 32'h0000_0200, 32'hA5A5_5A5A, 4'h1, 1'b1, 4'd15, 4'd1, 4'd4, 2'b00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cmd_req = 1'b0, cmd_write = 1'b0, cmd_strb_use = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [3:0]    cmd_strb = '0;
    logic [DL-1:0] cmd_addr_dly = '0, cmd_data_dly = '0;
    logic          busy, done, err;
    logic [DW-1:0] rd_data;
    logic [1:0]    resp_code;
    logic          m_awvalid, m_awready, m_wvalid, m_wready, m_arvalid, m_arready;
    logic          m_bready, m_rready;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic [DW-1:0] m_wdata;
    logic [3:0]    m_wstrb;
    logic          m_bvalid = 1'b0, m_rvalid = 1'b0;
    logic [1:0]    m_bresp = '0, m_rresp = '0;
    logic [DW-1:0] m_rdata = '0;

    axil_reg_master #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(DL)) i_axil_reg_master (.*);

    // Slave model state
    int            cur_lat = 0;
    logic [1:0]    cur_resp = '0;
    int            aw_cnt = 0, w_cnt = 0, ar_cnt = 0;
    logic          aw_seen = 1'b0, w_seen = 1'b0, ar_pend = 1'b0;
    logic [AW-1:0] got_awaddr = '0, got_araddr = '0;
    logic [DW-1:0] got_wdata = '0;
    logic [3:0]    got_wstrb = '0;
    int            n_aw = 0, n_ar = 0;
    int            cyc = 0, aw_start = -1, w_start = -1, ar_start = -1;

    assign m_awready = m_awvalid && (aw_cnt >= cur_lat);
    assign m_wready  = m_wvalid && (w_cnt >= cur_lat);
    assign m_arready = m_arvalid && (ar_cnt >= cur_lat);

    always @(posedge clk) begin
        if (!rst_n) begin
            aw_cnt <= 0; w_cnt <= 0; ar_cnt <= 0;
            aw_seen <= 1'b0; w_seen <= 1'b0; ar_pend <= 1'b0;
            m_bvalid <= 1'b0; m_rvalid <= 1'b0;
        end else begin
            aw_cnt <= (!m_awvalid || m_awready) ? 0 : aw_cnt + 1;
            w_cnt  <= (!m_wvalid || m_wready) ? 0 : w_cnt + 1;
            ar_cnt <= (!m_arvalid || m_arready) ? 0 : ar_cnt + 1;
            if (m_bvalid) begin
                m_bvalid <= 1'b0; aw_seen <= 1'b0; w_seen <= 1'b0;
            end else if (aw_seen && w_seen) begin
                m_bvalid <= 1'b1; m_bresp <= cur_resp;
            end
            if (m_awvalid && m_awready) begin
                aw_seen <= 1'b1; got_awaddr <= m_awaddr; n_aw <= n_aw + 1;
            end
            if (m_wvalid && m_wready) begin
                w_seen <= 1'b1; got_wdata <= m_wdata; got_wstrb <= m_wstrb;
            end
            if (m_rvalid) begin
                m_rvalid <= 1'b0;
            end else if (ar_pend) begin
                m_rvalid <= 1'b1; ar_pend <= 1'b0; m_rresp <= cur_resp;
                m_rdata <= got_araddr ^ 32'h5A5A_0000;
            end
            if (m_arvalid && m_arready) begin
                ar_pend <= 1'b1; got_araddr <= m_araddr; n_ar <= n_ar + 1;
            end
        end
        // Start-time monitor: edges since the accepting edge
        if (cmd_req && !busy && rst_n) begin
            cyc <= 0; aw_start <= -1; w_start <= -1; ar_start <= -1;
        end else begin
            cyc <= cyc + 1;
            if (m_awvalid && aw_start < 0) aw_start <= cyc;
            if (m_wvalid && w_start < 0) w_start <= cyc;
            if (m_arvalid && ar_start < 0) ar_start <= cyc;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        cur_lat = int'(v.lat); cur_resp = v.resp;
        cmd_write = v.wr; cmd_addr = v.addr; cmd_wdata = v.data;
        cmd_strb = v.strb; cmd_strb_use = v.strb_use;
        cmd_addr_dly = v.adly; cmd_data_dly = v.ddly;
        cmd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0;
    endtask

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic seen;
        logic [3:0] exp_strb;
        issue(v);
        check(busy == 1'b1, "R3 busy after accept", 64'(busy), 64'd1);
        wait_done(seen);
        check(seen, v.wr ? "R8 write done" : "R9 read done", 64'(seen), 64'd1);
        check(resp_code == v.resp, "R10 resp_code", 64'(resp_code), 64'(v.resp));
        check(err == (v.resp != 2'b00), "R10 err flag", 64'(err), 64'(v.resp != 2'b00));
        if (v.wr) begin
            exp_strb = v.strb_use ? v.strb : 4'hF;
            check(aw_start == int'(v.adly), "R4 aw start", 64'(aw_start), 64'(v.adly));
            check(w_start == int'(v.ddly), "R5 w start", 64'(w_start), 64'(v.ddly));
            check(got_awaddr == v.addr, "R6 awaddr", 64'(got_awaddr), 64'(v.addr));
            check(got_wdata == v.data, "R6 wdata", 64'(got_wdata), 64'(v.data));
            check(got_wstrb == exp_strb, "R7 wstrb", 64'(got_wstrb), 64'(exp_strb));
        end else begin
            check(ar_start == int'(v.adly), "R4 ar start", 64'(ar_start), 64'(v.adly));
            check(got_araddr == v.addr, "R6 araddr", 64'(got_araddr), 64'(v.addr));
            check(rd_data == (v.addr ^ 32'h5A5A_0000), "R9 rd_data", 64'(rd_data),
                  64'(v.addr ^ 32'h5A5A_0000));
        end
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 done one cycle, idle",
              64'({done, busy}), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int aw0, ar0;
        logic seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!m_awvalid && !m_wvalid && !m_arvalid, "R1 valids low in reset",
              64'({m_awvalid, m_wvalid, m_arvalid}), 64'd0);
        check(!busy && !done, "R1 busy/done low in reset", 64'({busy, done}), 64'd0);
        // R2 readies held high
        check(m_bready && m_rready, "R2 response readies", 64'({m_bready, m_rready}), 64'd3);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !m_awvalid, "R1 idle after reset", 64'({busy, m_awvalid}), 64'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R3: request during busy is ignored
        aw0 = n_aw; ar0 = n_ar;
        issue('{1'b1, 32'h0000_0300, 32'h0000_0001, 4'h0, 1'b0, 4'd0, 4'd0, 4'd8, 2'b00});
        cmd_write = 1'b0; cmd_addr = 32'h0000_0400; cmd_req = 1'b1;
        repeat (3) @(negedge clk);
        cmd_req = 1'b0;
        wait_done(seen);
        check(seen, "R8 write done after ignored request", 64'(seen), 64'd1);
        repeat (4) @(negedge clk);
        check(n_ar == ar0, "R3 no read issued while busy", 64'(n_ar), 64'(ar0));
        check(n_aw == aw0 + 1, "R3 exactly one address handshake", 64'(n_aw), 64'(aw0 + 1));

        // R11: reset mid-transaction
        issue('{1'b1, 32'h0000_0500, 32'h0000_0002, 4'h0, 1'b0, 4'd0, 4'd0, 4'd10, 2'b00});
        @(negedge clk);
        check(m_awvalid == 1'b1, "R11 transaction in flight", 64'(m_awvalid), 64'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!m_awvalid && !m_wvalid && !busy, "R11 reset abandons",
              64'({m_awvalid, m_wvalid, busy}), 64'd0);
        rst_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done || m_awvalid) seen = 1'b1;
        end
        check(!seen, "R11 no completion after reset", 64'(seen), 64'd0);
        run_vec(VECS[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule